// File: doc/BRIEF.md
# Register Link Self-Test Sequencer

This block sits on the host side of a register bridge and checks that the link works before the link carries real traffic. After a single-cycle start request it drives a request port on its own. The port offers register writes, register reads and block reads, with a valid/ready handshake on the request side and a valid strobe on the response side. The physical signalling behind the bridge is outside the block. All requests are issued in a fixed order, and each step waits for the bridge for as long as the bridge takes.

The test has two parts. The first part is two pattern passes. Each pass first loads a drive-select register with a pass-specific value. It then sweeps an index through every 8-bit value, scrambles the index with two different XOR keys, writes the results to two neighbouring task-file registers, and reads back the first of them. Each pass keeps its own count of wrong readbacks. The second part is one block read of 512 bytes from a fixed address. Only the first 128 bytes of that block are compared against an ascending byte ramp. When both parts are complete, the block gives a one-cycle completion pulse. It then holds the three error counts and a verdict until the next start. The verdict accepts a link whose errors are confined to one drive-select pass. It rejects the link when any block byte mismatches, or when both passes show errors.

States: `ST_IDLE`, `ST_SEL`, `ST_WR_A`, `ST_WR_B`, `ST_RD_A`, `ST_WAIT_A`, `ST_BLK`, `ST_STREAM`, `ST_DONE`. The transitions are as follows:
- idle to select on start.
- Select to first write, first write to second write, second write to read, and read to wait, each taken when the request is accepted.
- Wait to first write when a response arrives with more indices left in the pass.
- Wait back to select when a response arrives and the first pass is complete.
- Wait to block request when a response arrives and the second pass is complete.
- Block request to stream when the request is accepted.
- Stream to done on the 512th beat.
- Done to idle unconditionally.

Top module: `link_selftest_seq`

## Requirements
- R1: A `start` pulse in idle launches a run: `busy` rises one cycle later and all error counts and `pass_ok` clear. A `start` while `busy` has no effect on the run.
- R2: Each pass begins with a write of the drive-select register (address 6): 0xA0 for the first pass, 0xB0 for the second. Operation codes are write = 0, register read = 1, block read = 2.
- R3: For each index k from 0 to 255 in ascending order, the sequencer writes address 2 with k XOR 0xAA, then writes address 3 with k XOR 0x55, then reads address 2.
- R4: A readback of address 2 that differs from k XOR 0xAA increments the counter of the current pass. The counters are 9 bits wide, so they reach 256 without wrapping.
- R5: After the second pass, exactly one block-read request to address 0x10 is issued, and exactly 512 response beats are consumed.
- R6: Beat i for i < 128 is compared against the value i, and each mismatch increments `err_block`. Beats 128 to 511 never change any count.
- R7: `pass_ok` is 1 at completion only if `err_block` is 0 and at least one of the two pass counters is 0.
- R8: `done` is high for exactly one cycle. The counts and `pass_ok` then stay unchanged until the next accepted start.
- R9: A request is held with its operation, address and data unchanged until it is accepted. No request is raised while idle.
- R10: A response strobe outside the states that wait for data is ignored.
- R11: After reset the block is idle, with `done`, `pass_ok`, `req_valid` and all counts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a run when idle |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Bridge accepts the request |
| req_op | output | 2 | 0 write, 1 register read, 2 block read |
| req_addr | output | 8 | Register or block address |
| req_wdata | output | 8 | Write data |
| rsp_valid | input | 1 | One response byte present |
| rsp_data | input | 8 | Response byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass_ok | output | 1 | Verdict, valid from `done` until next start |
| err_pass0 | output | 9 | Readback errors in the 0xA0 pass |
| err_pass1 | output | 9 | Readback errors in the 0xB0 pass |
| err_block | output | 9 | Mismatches among the first 128 block bytes |

## Verification
The hardest situations to reach from the ports are those in which errors fall into exactly one drive-select pass, or reach the full count of 256 in one pass. Also hard to reach are block mismatches that lie only beyond byte 127, which must leave the verdict passing. The bench's bridge model tracks the last value written to the select register. It applies a separate XOR fault to address 2 readbacks in each pass, on indices chosen by a modulus. It also corrupts block bytes over a chosen range. Handshake stalls and response latency are randomised, and spurious strobes are injected while the block is idle.

// File: rtl/lst_pkg.sv
package lst_pkg;
    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_RD  = 2'd1,
        OP_BLK = 2'd2
    } lst_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_WR_A,
        ST_WR_B,
        ST_RD_A,
        ST_WAIT_A,
        ST_BLK,
        ST_STREAM,
        ST_DONE
    } lst_state_e;
endpackage

// File: rtl/lst_pattern.sv
module lst_pattern #(
    parameter int K_W    = 8,
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] SEL_BASE = 8'hA0,
    parameter logic [DATA_W-1:0] SEL_STEP = 8'h10,
    parameter logic [DATA_W-1:0] SCR_A    = 8'hAA,
    parameter logic [DATA_W-1:0] SCR_B    = 8'h55
) (
    input  logic [K_W-1:0]    k,
    input  logic              pass_sel,
    output logic [DATA_W-1:0] sel_val,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    logic [DATA_W-1:0] k_ext;

    always_comb begin
        k_ext   = DATA_W'(k);
        sel_val = SEL_BASE + (pass_sel ? SEL_STEP : '0);
        a_val   = k_ext ^ SCR_A;
        b_val   = k_ext ^ SCR_B;
    end
endmodule

// File: rtl/lst_beat_check.sv
module lst_beat_check #(
    parameter int IDX_W     = 9,
    parameter int DATA_W    = 8,
    parameter int CHECK_LEN = 128
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output logic              mismatch
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(CHECK_LEN);

    always_comb begin
        mismatch = (idx < LIMIT) && (data != DATA_W'(idx));
    end
endmodule

// File: rtl/lst_err_counter.sv
module lst_err_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/link_selftest_seq.sv
module link_selftest_seq #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int PATTERN_N = 256,
    parameter int BLOCK_LEN = 512,
    parameter int CHECK_LEN = 128,
    parameter logic [ADDR_W-1:0] SEL_ADDR   = 8'h06,
    parameter logic [ADDR_W-1:0] PAT_ADDR_A = 8'h02,
    parameter logic [ADDR_W-1:0] PAT_ADDR_B = 8'h03,
    parameter logic [ADDR_W-1:0] BLK_ADDR   = 8'h10,
    parameter logic [DATA_W-1:0] SEL_BASE   = 8'hA0,
    parameter logic [DATA_W-1:0] SEL_STEP   = 8'h10,
    parameter logic [DATA_W-1:0] SCR_A      = 8'hAA,
    parameter logic [DATA_W-1:0] SCR_B      = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic              done,
    output logic              pass_ok,
    output logic [$clog2(PATTERN_N):0] err_pass0,
    output logic [$clog2(PATTERN_N):0] err_pass1,
    output logic [$clog2(PATTERN_N):0] err_block
);
    import lst_pkg::*;

    localparam int K_W    = $clog2(PATTERN_N);
    localparam int CNT_W  = K_W + 1;
    localparam int IDX_W  = $clog2(BLOCK_LEN);
    localparam int N_CNT  = 3;
    localparam logic [K_W-1:0]   K_LAST   = K_W'(PATTERN_N - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLOCK_LEN - 1);

    lst_state_e       st_q, st_d;
    logic [K_W-1:0]   k_q;
    logic             pass_q;
    logic [IDX_W-1:0] idx_q;
    logic             have_q;

    logic [DATA_W-1:0] sel_val, a_val, b_val;
    logic              beat_bad;
    logic              last_k, last_idx;
    logic              launch;
    logic [N_CNT-1:0]  inc;
    logic [CNT_W-1:0]  cnt [N_CNT];

    lst_pattern #(
        .K_W(K_W), .DATA_W(DATA_W),
        .SEL_BASE(SEL_BASE), .SEL_STEP(SEL_STEP),
        .SCR_A(SCR_A), .SCR_B(SCR_B)
    ) u_pattern (
        .k(k_q), .pass_sel(pass_q),
        .sel_val(sel_val), .a_val(a_val), .b_val(b_val)
    );

    lst_beat_check #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .CHECK_LEN(CHECK_LEN)
    ) u_beat (
        .idx(idx_q), .data(rsp_data), .mismatch(beat_bad)
    );

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        lst_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(launch),
            .inc(inc[gi]), .cnt(cnt[gi])
        );
    end

    assign last_k   = (k_q == K_LAST);
    assign last_idx = (idx_q == IDX_LAST);
    assign launch   = (st_q == ST_IDLE) && start;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start)     st_d = ST_SEL;
            ST_SEL:    if (req_ready) st_d = ST_WR_A;
            ST_WR_A:   if (req_ready) st_d = ST_WR_B;
            ST_WR_B:   if (req_ready) st_d = ST_RD_A;
            ST_RD_A:   if (req_ready) st_d = ST_WAIT_A;
            ST_WAIT_A: if (rsp_valid) begin
                if (!last_k)     st_d = ST_WR_A;
                else if (pass_q) st_d = ST_BLK;
                else             st_d = ST_SEL;
            end
            ST_BLK:    if (req_ready) st_d = ST_STREAM;
            ST_STREAM: if (rsp_valid && last_idx) st_d = ST_DONE;
            ST_DONE:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register and sequencing indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            k_q    <= '0;
            pass_q <= 1'b0;
            idx_q  <= '0;
            have_q <= 1'b0;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    k_q    <= '0;
                    pass_q <= 1'b0;
                    have_q <= 1'b0;
                end
                ST_WAIT_A: if (rsp_valid) begin
                    k_q <= k_q + 1'b1;
                    if (last_k) pass_q <= 1'b1;
                end
                ST_BLK:    idx_q <= '0;
                ST_STREAM: begin
                    if (rsp_valid) idx_q <= idx_q + 1'b1;
                    if (rsp_valid && last_idx) have_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_valid = 1'b0;
        req_op    = OP_WR;
        req_addr  = '0;
        req_wdata = '0;
        inc       = '0;
        unique case (st_q)
            ST_SEL: begin
                req_valid = 1'b1;
                req_addr  = SEL_ADDR;
                req_wdata = sel_val;
            end
            ST_WR_A: begin
                req_valid = 1'b1;
                req_addr  = PAT_ADDR_A;
                req_wdata = a_val;
            end
            ST_WR_B: begin
                req_valid = 1'b1;
                req_addr  = PAT_ADDR_B;
                req_wdata = b_val;
            end
            ST_RD_A: begin
                req_valid = 1'b1;
                req_op    = OP_RD;
                req_addr  = PAT_ADDR_A;
            end
            ST_WAIT_A: begin
                inc[0] = rsp_valid && !pass_q && (rsp_data != a_val);
                inc[1] = rsp_valid &&  pass_q && (rsp_data != a_val);
            end
            ST_BLK: begin
                req_valid = 1'b1;
                req_op    = OP_BLK;
                req_addr  = BLK_ADDR;
            end
            ST_STREAM: inc[2] = rsp_valid && beat_bad;
            default: ;
        endcase
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = (st_q == ST_DONE);
    assign err_pass0 = cnt[0];
    assign err_pass1 = cnt[1];
    assign err_block = cnt[2];
    assign pass_ok   = have_q && (cnt[2] == '0) &&
                       ((cnt[0] == '0) || (cnt[1] == '0));
endmodule

// File: rtl/lst_checker.sv
module lst_checker #(
    parameter int CNT_W     = 9,
    parameter int CHECK_LEN = 128,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              busy,
    input logic              done,
    input logic              pass_ok,
    input logic [CNT_W-1:0]  err_pass0,
    input logic [CNT_W-1:0]  err_pass1,
    input logic [CNT_W-1:0]  err_block
);
    localparam logic [CNT_W-1:0] BLK_MAX = CNT_W'(CHECK_LEN);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op) && $stable(req_addr) && $stable(req_wdata)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(err_pass0) && $stable(err_pass1) && $stable(err_block) && $stable(pass_ok)); // R8
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && err_pass0 == '0 && err_pass1 == '0 && err_block == '0 && !pass_ok); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> err_pass0 >= $past(err_pass0) && err_pass1 >= $past(err_pass1)); // R4
    AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        err_block <= BLK_MAX); // R6
    AST_BLOCK_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_block != '0 |-> !pass_ok); // R7
    AST_BOTH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_pass0 != '0 && err_pass1 != '0 |-> !pass_ok); // R7
endmodule

bind link_selftest_seq lst_checker #(
    .CNT_W(CNT_W), .CHECK_LEN(CHECK_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .pass_ok(pass_ok),
    .err_pass0(err_pass0), .err_pass1(err_pass1), .err_block(err_block)
);

// File: tb/link_selftest_seq_test.sv
module link_selftest_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       req_valid, req_ready;
    logic [1:0] req_op;
    logic [7:0] req_addr, req_wdata;
    logic       rsp_valid = 1'b0;
    logic [7:0] rsp_data = 8'h00;
    logic       busy, done, pass_ok;
    logic [8:0] err_pass0, err_pass1, err_block;

    always #10 clk = ~clk;

    link_selftest_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .busy(busy), .done(done), .pass_ok(pass_ok),
        .err_pass0(err_pass0), .err_pass1(err_pass1), .err_block(err_block)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // bridge model configuration
    logic [7:0]  fmask [2];
    int unsigned fmod  [2];
    logic [7:0]  bmask;
    int unsigned bmod, blo, bhi;
    logic        noise_en = 1'b0;

    // bridge model state
    logic [7:0]  regs [8];
    logic [7:0]  sel_reg;
    int unsigned wr_k, sel_cnt, blk_reqs, wr_err, beats;
    logic        pend, blk_act;
    int unsigned lat, blk_i;
    logic [7:0]  rd_val;

    logic       a_q = 1'b0;
    logic [1:0] op_q;
    logic [7:0] addr_q, wd_q;

    function automatic int unsigned exp_pass(logic [7:0] m, int unsigned md);
        int unsigned n = 0;
        if (m == 8'h00) return 0;
        for (int k = 0; k < 256; k++) if ((k % md) == 0) n++;
        return n;
    endfunction

    function automatic logic blk_bad(int unsigned i);
        return (bmask != 8'h00) && (i >= blo) && (i <= bhi) && ((i % bmod) == 0);
    endfunction

    function automatic int unsigned exp_blk();
        int unsigned n = 0;
        for (int i = 0; i < 128; i++) if (blk_bad(i)) n++;
        return n;
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        a_q    <= req_valid && req_ready;
        op_q   <= req_op;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
    end

    // bridge model: inputs driven at the falling edge
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (!rst_n) begin
            pend = 1'b0; blk_act = 1'b0; req_ready = 1'b0;
        end else begin
            if (a_q) begin
                case (op_q)
                    2'd0: begin
                        if (addr_q == 8'h06) begin
                            if (wd_q != (8'hA0 + 8'h10 * 8'(sel_cnt))) wr_err++;
                            sel_cnt++; sel_reg = wd_q; wr_k = 0;
                        end else if (addr_q == 8'h02) begin
                            if (wd_q != (8'(wr_k) ^ 8'hAA)) wr_err++;
                            regs[2] = wd_q;
                        end else if (addr_q == 8'h03) begin
                            if (wd_q != (8'(wr_k) ^ 8'h55)) wr_err++;
                            regs[3] = wd_q;
                        end else wr_err++;
                    end
                    2'd1: begin
                        if (addr_q != 8'h02) wr_err++;
                        rd_val = regs[2];
                        if (sel_reg == 8'hA0 && (wr_k % fmod[0]) == 0) rd_val ^= fmask[0];
                        if (sel_reg == 8'hB0 && (wr_k % fmod[1]) == 0) rd_val ^= fmask[1];
                        wr_k++;
                        pend = 1'b1; lat = $urandom % 4;
                    end
                    default: begin
                        if (addr_q != 8'h10) wr_err++;
                        blk_reqs++; blk_act = 1'b1; blk_i = 0;
                    end
                endcase
            end
            if (pend) begin
                if (lat == 0) begin
                    rsp_valid = 1'b1; rsp_data = rd_val; pend = 1'b0;
                end else lat--;
            end else if (blk_act) begin
                if (($urandom % 3) != 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = 8'(blk_i) ^ (blk_bad(blk_i) ? bmask : 8'h00);
                    blk_i++; beats++;
                    if (blk_i == 512) blk_act = 1'b0;
                end
            end else if (noise_en) begin
                rsp_valid = ($urandom % 2) == 1;
                rsp_data  = 8'($urandom);
            end
            req_ready = ($urandom % 4) != 0;
        end
    end

    task automatic run(input string name, input logic mid_start);
        int unsigned e0, e1, eb;
        logic ok, seen;
        e0 = exp_pass(fmask[0], fmod[0]);
        e1 = exp_pass(fmask[1], fmod[1]);
        eb = exp_blk();
        ok = (eb == 0) && ((e0 == 0) || (e1 == 0));
        @(posedge clk); #2;
        sel_cnt = 0; blk_reqs = 0; wr_err = 0; beats = 0;
        start = 1'b1;
        @(posedge clk); #2;
        start = 1'b0;
        @(negedge clk);
        chk(busy && err_pass0 == 0 && err_pass1 == 0 && err_block == 0 && !pass_ok,
            {"R1 launch/clear ", name}, int'(busy), 1);
        seen = 1'b0;
        for (int t = 0; t < 30000 && !seen; t++) begin
            @(negedge clk);
            if (mid_start && t == 40) start = 1'b1;
            if (mid_start && t == 41) start = 1'b0;
            if (done) seen = 1'b1;
        end
        chk(seen, {"R8 done reached ", name}, int'(seen), 1);
        chk(err_pass0 == e0, {"R4 err_pass0 ", name}, int'(err_pass0), int'(e0));
        chk(err_pass1 == e1, {"R4 err_pass1 ", name}, int'(err_pass1), int'(e1));
        chk(err_block == eb, {"R6 err_block ", name}, int'(err_block), int'(eb));
        chk(pass_ok == ok, {"R7 verdict ", name}, int'(pass_ok), int'(ok));
        chk(wr_err == 0, {"R3 write/read values ", name}, int'(wr_err), 0);
        chk(sel_cnt == 2, {"R2 select writes ", name}, int'(sel_cnt), 2);
        chk(blk_reqs == 1 && beats == 512, {"R5 block request/beats ", name}, int'(beats), 512);
        @(negedge clk);
        chk(!done && !busy, {"R8 done one cycle ", name}, int'(done), 0);
        noise_en = 1'b1;
        repeat (40) @(negedge clk);
        noise_en = 1'b0;
        chk(err_pass0 == e0 && err_pass1 == e1 && err_block == eb && pass_ok == ok && !req_valid,
            {"R10 idle strobes ignored ", name}, int'(err_block), int'(eb));
    endtask

    task automatic cfg(input logic [7:0] m0, input int unsigned d0,
                       input logic [7:0] m1, input int unsigned d1,
                       input logic [7:0] bm, input int unsigned bd,
                       input int unsigned lo, input int unsigned hi);
        fmask[0] = m0; fmod[0] = d0; fmask[1] = m1; fmod[1] = d1;
        bmask = bm; bmod = bd; blo = lo; bhi = hi;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cfg(8'h00, 1, 8'h00, 1, 8'h00, 1, 0, 0);
        sel_reg = 8'h00; wr_k = 0; sel_cnt = 0; blk_reqs = 0; wr_err = 0; beats = 0;
        regs[2] = 8'h00; regs[3] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !pass_ok && !req_valid && err_pass0 == 0 && err_pass1 == 0 && err_block == 0,
            "R11 reset state", int'(busy), 0);

        run("clean", 1'b0);
        cfg(8'h01, 1 + $urandom % 9, 8'h00, 1, 8'h00, 1, 0, 0);
        run("pass0 only", 1'b0);
        cfg(8'h00, 1, 8'h80, 1 + $urandom % 9, 8'h00, 1, 0, 0);
        run("pass1 only", 1'b0);
        cfg(8'h10, 3, 8'h04, 5, 8'h00, 1, 0, 0);
        run("both passes", 1'b0);
        cfg(8'hFF, 1, 8'h01, 1, 8'h00, 1, 0, 0);
        run("all 256 errors", 1'b0);
        cfg(8'h00, 1, 8'h00, 1, 8'h20, 1 + $urandom % 6, 0, 127);
        run("block head", 1'b0);
        cfg(8'h00, 1, 8'h00, 1, 8'h01, 1, 128, 511);
        run("block tail + busy start", 1'b1);
        cfg(8'h02, 1, 8'h00, 1, 8'h40, 1, 127, 127);
        run("last checked byte", 1'b0);
        for (int r = 0; r < 3; r++) begin
            cfg(($urandom % 2) ? 8'(1 + $urandom % 255) : 8'h00, 1 + $urandom % 17,
                ($urandom % 2) ? 8'(1 + $urandom % 255) : 8'h00, 1 + $urandom % 17,
                ($urandom % 3 == 0) ? 8'(1 + $urandom % 255) : 8'h00, 1 + $urandom % 11,
                $urandom % 200, 200 + $urandom % 312);
            run("random", 1'b0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule